// File: doc/BRIEF.md
# Keyed Register Write-Protect Guard

This block sits on a simple register bus in front of a small bank of system control registers and decides, bit by bit, whether a write is allowed to land. Out of reset every guarded bit is frozen. Software opens the guard by writing an exact 16-bit key value to a dedicated key register. The guard then stays open across any number of bus writes until software writes any other value to the key register, which closes it again.

Two example control registers sit behind the guard. Each has a constant per-bit protect mask: bits set in the mask keep their old value while the guard is closed, and bits clear in the mask always follow the written data. Bit 0 of the first control register is a cache-enable control. An accepted write of 0 to that bit raises a cache-invalidate pulse for one cycle.

The lock is held by a two-state machine. The states are LOCKED and OPEN. The transition UNLOCK goes from LOCKED to OPEN on a key-register write of exactly the key. The transition RELOCK goes from OPEN to LOCKED on a key-register write of any other value. Every other cycle keeps the current state.

Top module: `wp_guard_top`

## Requirements
- R1: The key register (address 0) is 16 bits wide. A read returns the last value written to it, and it reads 0x0000 after reset.
- R2: A write of exactly 0x0096 to address 0 opens the guard from the next clock edge on. The status bit and the `locked` port then read 0.
- R3: A write of any value other than 0x0096 to address 0 closes the guard from the next clock edge on, whatever the previous state.
- R4: After the synchronous active-low reset, the guard is closed, `locked` is 1, and both control registers read 0x0000.
- R5: The lock state changes only on writes to address 0. Writes to other addresses, and cycles without a write, leave it unchanged.
- R6: While the guard is closed, a write to control register A (address 1, mask 0x00FF) or B (address 2, mask 0xF0F0) leaves the masked bits unchanged and loads the unmasked bits from the write data. The result is visible after the next edge.
- R7: While the guard is open, a write to control register A or B loads all 16 bits of the write data.
- R8: `cache_en` mirrors bit 0 of control register A. `cache_inval` is 1 for exactly the cycle after a write to address 1 that carries 0 in bit 0 and is not blocked by the lock; otherwise it is 0.
- R9: Address 3 is a read-only status word: bit 0 is the lock state (1 = locked) and bits 15:1 read 0. Writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 key, 1 control A, 2 control B, 3 status |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| locked | output | 1 | 1 while protected bits are frozen |
| cache_en | output | 1 | Cache enable, bit 0 of control register A |
| cache_inval | output | 1 | One-cycle cache invalidate pulse |

## Verification
A wrong lock state shows up on the `locked` port and on status bit 0 one edge after the offending key write. It also shows up on the first following write to a control register, whose masked bits either move when they should hold or hold when they should move. A bad mask or merge shows up in the read-back of that register on the cycle after the write. A misplaced invalidate pulse shows up as `cache_inval` asserted in the wrong cycle, or missing in the cycle after an accepted write of 0.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
    localparam int unsigned DATA_W = 16;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_CTLA = 2'd1;
    localparam logic [1:0] ADDR_CTLB = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/wp_lock_fsm.sv
module wp_lock_fsm
    import wp_guard_pkg::*;
#(
    parameter int unsigned DW  = DATA_W,
    parameter logic [DW-1:0] KEY = 16'h0096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [DW-1:0] key_wdata,
    output logic [DW-1:0] key_q,
    output logic          locked
);
    lock_state_e state_q, state_d;
    logic        key_match;

    assign key_match = (key_wdata == KEY);

    // state register and key storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            if (key_we) key_q <= key_wdata;
        end
    end

    // transitions: UNLOCK and RELOCK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_we && key_match)  state_d = ST_OPEN;
            ST_OPEN:   if (key_we && !key_match) state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        locked = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/wp_guard_reg.sv
module wp_guard_reg #(
    parameter int unsigned   DW   = 16,
    parameter logic [DW-1:0] MASK = '0,
    parameter logic [DW-1:0] RST  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          lock,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] merged;

    // per-bit guard: frozen bits keep q, free bits take wdata
    always_comb begin
        if (lock) merged = (q & MASK) | (wdata & ~MASK);
        else      merged = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= merged;
    end
endmodule

// File: rtl/wp_guard_top.sv
module wp_guard_top
    import wp_guard_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY    = 16'h0096,
    parameter logic [DATA_W-1:0] MASK_A = 16'h00FF,
    parameter logic [DATA_W-1:0] MASK_B = 16'hF0F0,
    parameter logic [DATA_W-1:0] RST_A  = 16'h0000,
    parameter logic [DATA_W-1:0] RST_B  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              locked,
    output logic              cache_en,
    output logic              cache_inval
);
    localparam int unsigned NREG = 2;
    localparam logic [NREG*DATA_W-1:0] MASKS = {MASK_B, MASK_A};
    localparam logic [NREG*DATA_W-1:0] RSTS  = {RST_B, RST_A};

    logic [DATA_W-1:0] key_q;
    logic [DATA_W-1:0] ctrl_q [NREG];
    logic [NREG-1:0]   ctrl_we;
    logic              inval_q;
    logic              bit0_free;

    wp_lock_fsm #(.DW(DATA_W), .KEY(KEY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (bus_we && bus_addr == ADDR_KEY),
        .key_wdata(bus_wdata),
        .key_q    (key_q),
        .locked   (locked)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_ctrl
        assign ctrl_we[g] = bus_we && (bus_addr == 2'(g + 1));
        wp_guard_reg #(
            .DW  (DATA_W),
            .MASK(MASKS[g*DATA_W +: DATA_W]),
            .RST (RSTS[g*DATA_W +: DATA_W])
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (ctrl_we[g]),
            .lock (locked),
            .wdata(bus_wdata),
            .q    (ctrl_q[g])
        );
    end

    assign cache_en  = ctrl_q[0][0];
    assign bit0_free = !(locked && MASK_A[0]);

    always_ff @(posedge clk) begin
        if (!rst_n) inval_q <= 1'b0;
        else        inval_q <= ctrl_we[0] && !bus_wdata[0] && bit0_free;
    end
    assign cache_inval = inval_q;

    always_comb begin
        unique case (bus_addr)
            ADDR_KEY:  bus_rdata = key_q;
            ADDR_CTLA: bus_rdata = ctrl_q[0];
            ADDR_CTLB: bus_rdata = ctrl_q[1];
            ADDR_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, locked};
        endcase
    end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter logic [15:0] KEY    = 16'h0096,
    parameter logic [15:0] MASK_A = 16'h00FF,
    parameter logic [15:0] MASK_B = 16'hF0F0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_we,
    input logic [15:0] bus_wdata,
    input logic        locked,
    input logic        cache_en,
    input logic        cache_inval,
    input logic [15:0] ctrl_a,
    input logic [15:0] ctrl_b
);
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0 && bus_wdata == KEY) |=> !locked);

    p_other_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0 && bus_wdata != KEY) |=> locked);

    p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 2'd0) |=> $stable(locked));

    p_frozen_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1 && locked) |=> ((ctrl_a & MASK_A) == ($past(ctrl_a) & MASK_A)));

    p_frozen_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2 && locked) |=> ((ctrl_b & MASK_B) == ($past(ctrl_b) & MASK_B)));

    p_inval_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cache_inval |-> !cache_en);

    p_no_inval_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 2'd1) |=> !cache_inval);
endmodule

bind wp_guard_top wp_guard_chk #(.KEY(KEY), .MASK_A(MASK_A), .MASK_B(MASK_B)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .locked     (locked),
    .cache_en   (cache_en),
    .cache_inval(cache_inval),
    .ctrl_a     (ctrl_q[0]),
    .ctrl_b     (ctrl_q[1])
);

// File: tb/sim_wp_guard_top.sv
`timescale 1ns/1ps
module sim_wp_guard_top;
    localparam logic [15:0] KEY    = 16'h0096;
    localparam logic [15:0] MASK_A = 16'h00FF;
    localparam logic [15:0] MASK_B = 16'hF0F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        locked, cache_en, cache_inval;

    int unsigned errors = 0;
    int unsigned checks = 0;
    logic [15:0] m_key, m_a, m_b;
    logic        m_lock, m_inval;

    always #2 clk = ~clk;

    wp_guard_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .locked(locked),
        .cache_en(cache_en), .cache_inval(cache_inval)
    );

    function automatic logic [15:0] guard_next(logic [15:0] old, logic [15:0] wd,
                                               logic [15:0] mask, logic lk);
        return lk ? ((old & mask) | (wd & ~mask)) : wd;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_all(string req);
        bus_we = 1'b0;
        bus_addr = 2'd0; #0.2; check({req, " R1 key"}, bus_rdata, m_key);
        bus_addr = 2'd1; #0.2; check({req, " ctrlA"}, bus_rdata, m_a);
        bus_addr = 2'd2; #0.2; check({req, " ctrlB"}, bus_rdata, m_b);
        bus_addr = 2'd3; #0.2; check({req, " R9 status"}, bus_rdata, {15'h0, m_lock});
        check({req, " lock port"}, {15'h0, locked}, {15'h0, m_lock});
        check({req, " R8 cache_en"}, {15'h0, cache_en}, {15'h0, m_a[0]});
        check({req, " R8 inval"}, {15'h0, cache_inval}, {15'h0, m_inval});
    endtask

    // drive at negedge, model updates on the edge, check at next negedge
    task automatic wr(logic [1:0] a, logic [15:0] d, string req);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        m_inval = 1'b0;
        unique case (a)
            2'd0: begin m_key = d; m_lock = (d != KEY); end
            2'd1: begin
                m_inval = !d[0] && !(m_lock && MASK_A[0]);
                m_a = guard_next(m_a, d, MASK_A, m_lock);
            end
            2'd2: m_b = guard_next(m_b, d, MASK_B, m_lock);
            2'd3: ;
        endcase
        @(posedge clk); @(negedge clk);
        read_all(req);
    endtask

    task automatic idle(string req);
        bus_we = 1'b0; m_inval = 1'b0;
        @(posedge clk); @(negedge clk);
        read_all(req);
    endtask

    initial begin
        #(4.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        m_key = 0; m_a = 0; m_b = 0; m_lock = 1; m_inval = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_all("R4 reset");
        // R6 locked partial writes
        wr(2'd1, 16'hFFFF, "R6 locked A");
        wr(2'd2, 16'hFFFF, "R6 locked B");
        // R8 blocked zero write: no pulse
        wr(2'd1, 16'hFF00, "R8 blocked");
        // R3 near-miss key
        wr(2'd0, 16'h0097, "R3 near key");
        wr(2'd0, 16'h9600, "R3 swapped key");
        // R2 unlock
        wr(2'd0, KEY, "R2 unlock");
        // R5 persistence
        wr(2'd3, 16'hFFFF, "R9 status write ignored");
        wr(2'd1, 16'h1235, "R7 open A");
        wr(2'd2, 16'hABCD, "R7 open B");
        idle("R5 idle");
        wr(2'd0, KEY, "R5 key again");
        // R8 accepted zero write gives pulse, then drops
        wr(2'd1, 16'h0000, "R8 pulse");
        idle("R8 pulse ends");
        wr(2'd1, 16'h0001, "R8 enable");
        wr(2'd0, 16'h0000, "R3 relock");
        wr(2'd1, 16'h5550, "R6 relocked A");
        // R4 reset mid-run
        wr(2'd0, KEY, "R2 unlock2");
        wr(2'd2, 16'h7777, "R7 B");
        rst_n = 1'b0; bus_we = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_key = 0; m_a = 0; m_b = 0; m_lock = 1; m_inval = 0;
        read_all("R4 reset2");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  a;
            logic [15:0] d;
            a = 2'($urandom_range(0, 3));
            d = 16'($urandom);
            if (a == 2'd0 && $urandom_range(0, 1) == 1) d = KEY;
            if ($urandom_range(0, 4) == 0) idle("R5 rand idle");
            else wr(a, d, "R6/R7 rand");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule